// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations. A lookup presents a virtual address, an address-space identifier and an access kind. The virtual page number and the identifier are compared against every stored entry at the same time. When an entry matches and its permission bits allow the access, the block returns a physical address. That address is the entry's frame number with the 12-bit page offset appended unchanged. When an entry matches but the permissions do not allow the access, the block raises a fault and returns no translation. When no entry matches, it reports a miss.

Each entry holds a page number, an identifier, a frame number, three permission bits, and valid, use and dirty flags. Because entries carry the identifier, translations from several processes can sit in the buffer together, and a context switch needs no flush. The page-table walker installs translations through a refill port. The refill port writes the slot chosen by a round-robin pointer. A flush input invalidates either the entries of one identifier or all entries. Lookup results are combinational. All state changes take effect at the next rising clock edge.

Top module: `tlb_top`

## Requirements
- R1: A lookup (lk_valid_i high) misses in the same cycle unless some valid entry has both the page number (vaddr bits 31:12) and the identifier equal to the request.
- R2: A permitted matching lookup raises lk_hit_o in the same cycle.
- R3: While lk_valid_i is high, exactly one of lk_hit_o, lk_miss_o and lk_fault_o is high. While it is low, all three are low. lk_paddr_o is zero unless lk_hit_o is high.
- R4: Access kind encoding is 0 = read, 1 = write, 2 = execute, 3 = reserved. The permission field has bit 0 = read, bit 1 = write and bit 2 = execute. A matching lookup whose kind has its permission bit clear raises lk_fault_o instead of lk_hit_o. Kind 3 always faults.
- R5: On a hit, lk_paddr_o is the entry's 20-bit frame number in bits 31:12, and vaddr bits 11:0 are copied unchanged into bits 11:0.
- R6: A matching lookup (hit or fault) sets the entry's use flag from the next cycle on. lk_use_o shows the flag's value before this lookup, and is 0 when nothing matches.
- R7: A permitted write hit sets the entry's dirty flag. A read, an execute or a faulting write leaves it unchanged. lk_dirty_o shows the flag's value before this lookup, and is 0 when nothing matches.
- R8: A refill writes the slot at the round-robin pointer and clears that slot's use and dirty flags. The pointer then advances by one, wrapping from 15 to 0.
- R9: Flush with flush_all_i high invalidates every entry. With flush_all_i low, it invalidates only the entries whose identifier equals flush_asid_i.
- R10: A refill presented in the same cycle as a flush is dropped, and the pointer does not move.
- R11: Entries with the same page number but different identifiers coexist, and each lookup returns its own identifier's frame.
- R12: If several valid entries match a lookup, the lowest-numbered slot supplies the result.
- R13: After reset, all entries are invalid and the pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address |
| lk_asid_i | input | 8 | Identifier of the requesting process |
| lk_acc_i | input | 2 | Access kind (R4) |
| lk_hit_o | output | 1 | Translation valid |
| lk_miss_o | output | 1 | No matching entry |
| lk_fault_o | output | 1 | Matching entry denies the access |
| lk_paddr_o | output | 32 | Physical address |
| lk_use_o | output | 1 | Matched entry's use flag before this lookup |
| lk_dirty_o | output | 1 | Matched entry's dirty flag before this lookup |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | 20 | Page number to install |
| fill_asid_i | input | 8 | Identifier to install |
| fill_pfn_i | input | 20 | Frame number to install |
| fill_perm_i | input | 3 | Permission bits to install |
| flush_i | input | 1 | Flush request |
| flush_all_i | input | 1 | Flush every entry instead of one identifier |
| flush_asid_i | input | 8 | Identifier to flush |

## Verification
The bench targets several cases a faulty design could get wrong. Two entries share a page number but have different identifiers; a design that ignored the identifier would return the wrong frame. A duplicate entry sits at a lower slot; a design with the wrong priority would pick the higher slot's frame. A write is made to a page without write permission; a design that set the dirty flag anyway would later report that page as modified. Refills are filled past slot 15, so a pointer that fails to wrap would write outside the array. A refill arrives in the same cycle as a flush; a design that let it through would leave a live entry and shift the pointer. A long random phase over a small page and identifier space mixes all of these with partial flushes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  function automatic logic acc_allowed(input logic [1:0] acc, input logic [PERM_W-1:0] perm);
    case (acc)
      ACC_READ:  return perm[PERM_RD];
      ACC_WRITE: return perm[PERM_WR];
      ACC_EXEC:  return perm[PERM_EX];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]         key_vpn_i,
  input  logic [ASID_W-1:0]        key_asid_i,
  output logic [N-1:0]             match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     oh_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    oh_o  = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        oh_o  = '0;
        oh_o[i] = 1'b1;
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == IDX_W'(N - 1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/tlb_top.sv
module tlb_top #(
  parameter int N      = 16,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  parameter int OFF_W  = 12,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PFN_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [1:0]        lk_acc_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic              lk_use_o,
  output logic              lk_dirty_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [2:0]        fill_perm_i,
  input  logic              flush_i,
  input  logic              flush_all_i,
  input  logic [ASID_W-1:0] flush_asid_i
);
  import tlb_pkg::*;

  logic [N-1:0]             valid_q, use_q, dirty_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;
  logic [N-1:0][PFN_W-1:0]  pfn_q;
  logic [N-1:0][PERM_W-1:0] perm_q;

  logic [N-1:0]     match_raw, match_oh, flush_hit;
  logic [IDX_W-1:0] match_idx, fill_ptr_q;
  logic             any_match, perm_ok, fill_go, wr_hit;

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
    .valid_i    (valid_q),
    .vpn_i      (vpn_q),
    .asid_i     (asid_q),
    .key_vpn_i  (lk_vaddr_i[VA_W-1:OFF_W]),
    .key_asid_i (lk_asid_i),
    .match_o    (match_raw)
  );

  tlb_pick #(.N(N)) u_pick (
    .req_i (match_raw),
    .oh_o  (match_oh),
    .idx_o (match_idx),
    .any_o (any_match)
  );

  assign perm_ok    = acc_allowed(lk_acc_i, perm_q[match_idx]);
  assign lk_hit_o   = lk_valid_i && any_match && perm_ok;
  assign lk_fault_o = lk_valid_i && any_match && !perm_ok;
  assign lk_miss_o  = lk_valid_i && !any_match;
  assign lk_paddr_o = lk_hit_o ? {pfn_q[match_idx], lk_vaddr_i[OFF_W-1:0]} : '0;
  assign lk_use_o   = (lk_valid_i && any_match) ? use_q[match_idx]   : 1'b0;
  assign lk_dirty_o = (lk_valid_i && any_match) ? dirty_q[match_idx] : 1'b0;
  assign wr_hit     = lk_hit_o && (lk_acc_i == ACC_WRITE);

  // flush wins over a refill in the same cycle
  assign fill_go = fill_valid_i && !flush_i;

  tlb_rr_ptr #(.N(N)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fill_go),
    .ptr_o  (fill_ptr_q)
  );

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic fill_here;
    assign flush_hit[g] = flush_i && (flush_all_i || asid_q[g] == flush_asid_i);
    assign fill_here    = fill_go && (fill_ptr_q == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        use_q[g]   <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else begin
        if (lk_valid_i && match_oh[g]) begin
          use_q[g] <= 1'b1;
          if (wr_hit) dirty_q[g] <= 1'b1;
        end
        if (flush_hit[g]) valid_q[g] <= 1'b0;
        if (fill_here) begin
          valid_q[g] <= 1'b1;
          use_q[g]   <= 1'b0;
          dirty_q[g] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (fill_here) begin
        vpn_q[g]  <= fill_vpn_i;
        asid_q[g] <= fill_asid_i;
        pfn_q[g]  <= fill_pfn_i;
        perm_q[g] <= fill_perm_i;
      end
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int N     = 16,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_valid_i,
  input logic [VA_W-1:0]  lk_vaddr_i,
  input logic             lk_hit_o,
  input logic             lk_miss_o,
  input logic             lk_fault_o,
  input logic [PA_W-1:0]  lk_paddr_o,
  input logic             fill_valid_i,
  input logic             flush_i,
  input logic             flush_all_i,
  input logic [N-1:0]     valid_q,
  input logic [N-1:0]     use_q,
  input logic [N-1:0]     dirty_q,
  input logic [N-1:0]     match_oh,
  input logic [IDX_W-1:0] fill_ptr_q
);
  a_r3_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> $countones({lk_hit_o, lk_miss_o, lk_fault_o}) == 1);

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_fault_o));

  a_r3_no_addr_unless_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_paddr_o == '0);

  a_r5_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_o[OFF_W-1:0] == lk_vaddr_i[OFF_W-1:0]);

  a_r6_use_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && (lk_hit_o || lk_fault_o) && !fill_valid_i && !flush_i)
      |=> (use_q & $past(match_oh)) != '0);

  a_r7_fault_keeps_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_fault_o && !fill_valid_i)
      |=> (dirty_q & $past(match_oh)) == ($past(dirty_q) & $past(match_oh)));

  a_r8_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i)
      |=> fill_ptr_q == (($past(fill_ptr_q) == IDX_W'(N - 1)) ? '0 : $past(fill_ptr_q) + 1'b1));

  a_r9_flush_all_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && flush_all_i) |=> valid_q == '0);

  a_r10_ptr_holds_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> $stable(fill_ptr_q));
endmodule

bind tlb_top tlb_chk #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lk_valid_i   (lk_valid_i),
  .lk_vaddr_i   (lk_vaddr_i),
  .lk_hit_o     (lk_hit_o),
  .lk_miss_o    (lk_miss_o),
  .lk_fault_o   (lk_fault_o),
  .lk_paddr_o   (lk_paddr_o),
  .fill_valid_i (fill_valid_i),
  .flush_i      (flush_i),
  .flush_all_i  (flush_all_i),
  .valid_q      (valid_q),
  .use_q        (use_q),
  .dirty_q      (dirty_q),
  .match_oh     (match_oh),
  .fill_ptr_q   (fill_ptr_q)
);

// File: tb/tlb_top_tb.sv
module tlb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_acc = '0;
  logic        hit, miss, fault, use_f, dirty_f;
  logic [31:0] paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        flush_all = 1'b0;
  logic [7:0]  flush_asid = '0;

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R13";

  // reference model
  bit m_valid[NE];
  bit m_use[NE];
  bit m_dirty[NE];
  int m_vpn[NE];
  int m_asid[NE];
  int m_pfn[NE];
  int m_perm[NE];
  int m_ptr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_asid_i(lk_asid), .lk_acc_i(lk_acc),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_fault_o(fault), .lk_paddr_o(paddr),
    .lk_use_o(use_f), .lk_dirty_o(dirty_f),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_perm_i(fill_perm),
    .flush_i(flush), .flush_all_i(flush_all), .flush_asid_i(flush_asid)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit allowed(input int acc, input int perm);
    case (acc)
      0: return perm[0];
      1: return perm[1];
      2: return perm[2];
      default: return 1'b0;
    endcase
  endfunction

  // one cycle: compare mid-cycle, then update model at the edge
  task automatic cycle();
    int m = -1;
    bit ok, eh, ef, em;
    logic [31:0] ep;
    #(CLK_PERIOD / 4);
    for (int i = 0; i < NE; i++)
      if (m < 0 && m_valid[i] && m_vpn[i] == int'(lk_vaddr[31:12]) && m_asid[i] == int'(lk_asid)) m = i;
    ok = (m >= 0) ? allowed(int'(lk_acc), m_perm[m]) : 1'b0;
    eh = lk_valid && m >= 0 && ok;
    ef = lk_valid && m >= 0 && !ok;
    em = lk_valid && m < 0;
    ep = eh ? {m_pfn[m][19:0], lk_vaddr[11:0]} : 32'h0;
    chk("hit", 32'(hit), 32'(eh));
    chk("miss", 32'(miss), 32'(em));
    chk("fault", 32'(fault), 32'(ef));
    chk("paddr", paddr, ep);
    chk("use", 32'(use_f), 32'((lk_valid && m >= 0) ? m_use[m] : 1'b0));
    chk("dirty", 32'(dirty_f), 32'((lk_valid && m >= 0) ? m_dirty[m] : 1'b0));
    @(posedge clk);
    if (lk_valid && m >= 0) begin
      m_use[m] = 1'b1;
      if (eh && lk_acc == 2'd1) m_dirty[m] = 1'b1;
    end
    if (flush) begin
      for (int i = 0; i < NE; i++)
        if (flush_all || m_asid[i] == int'(flush_asid)) m_valid[i] = 1'b0;
    end else if (fill_valid) begin
      m_valid[m_ptr] = 1'b1; m_use[m_ptr] = 1'b0; m_dirty[m_ptr] = 1'b0;
      m_vpn[m_ptr] = int'(fill_vpn); m_asid[m_ptr] = int'(fill_asid);
      m_pfn[m_ptr] = int'(fill_pfn); m_perm[m_ptr] = int'(fill_perm);
      m_ptr = (m_ptr + 1) % NE;
    end
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0; flush_all = 1'b0;
  endtask

  task automatic look(input int vpn, input int asid, input int acc, input int off);
    lk_valid = 1'b1; lk_vaddr = {vpn[19:0], off[11:0]}; lk_asid = asid[7:0]; lk_acc = acc[1:0];
    cycle();
  endtask

  task automatic fill(input int vpn, input int asid, input int pfn, input int perm);
    fill_valid = 1'b1; fill_vpn = vpn[19:0]; fill_asid = asid[7:0];
    fill_pfn = pfn[19:0]; fill_perm = perm[2:0];
    cycle();
  endtask

  task automatic do_flush(input bit all, input int asid);
    flush = 1'b1; flush_all = all; flush_asid = asid[7:0];
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_valid[i] = 0; m_use[i] = 0; m_dirty[i] = 0;
      m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R13";
    look(0, 0, 0, 0);
    look(1, 5, 0, 'h123);

    tag = "R8";
    for (int i = 0; i < NE; i++) fill(i + 1, (i < 8) ? 5 : 9, 'h80000 + i * 3, i % 8);

    tag = "R3";
    cycle();

    tag = "R2";
    for (int i = 0; i < NE; i++) look(i + 1, (i < 8) ? 5 : 9, 0, 'hABC);
    tag = "R5";
    look(2, 5, 0, 'hFFF);
    look(10, 9, 0, 'h001);
    tag = "R1";
    look(2, 9, 0, 0);
    look(40, 5, 0, 0);

    tag = "R4";
    for (int i = 0; i < 8; i++) begin
      look(i + 1, 5, 1, 'h10);
      look(i + 1, 5, 2, 'h20);
      look(i + 1, 5, 3, 'h30);
    end
    tag = "R7";
    for (int i = 0; i < 8; i++) look(i + 1, 5, 0, 0);
    tag = "R6";
    look(16, 9, 1, 0);
    look(16, 9, 0, 0);

    tag = "R11";
    fill(3, 9, 'h44444, 7);
    look(3, 9, 0, 'h5);
    look(3, 5, 0, 'h5);
    tag = "R12";
    fill(4, 5, 'h55555, 7);
    look(4, 5, 0, 'h6);
    look(1, 5, 0, 0);

    tag = "R9";
    do_flush(1'b0, 9);
    for (int i = 0; i < NE; i++) look(i + 1, (i < 8) ? 5 : 9, 0, 0);
    look(3, 9, 0, 0);
    do_flush(1'b1, 0);
    for (int i = 0; i < NE; i++) look(i + 1, (i < 8) ? 5 : 9, 0, 0);

    tag = "R10";
    fill_valid = 1'b1; fill_vpn = 20'd77; fill_asid = 8'd1; fill_pfn = 20'h1234; fill_perm = 3'd7;
    do_flush(1'b0, 3);
    look(77, 1, 0, 0);
    fill(78, 1, 'h2222, 7);
    fill(79, 1, 'h3333, 7);
    look(78, 1, 0, 0);
    look(79, 1, 1, 0);

    tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      lk_valid = ($urandom_range(0, 3) != 0);
      lk_vaddr = {17'd0, 3'($urandom_range(0, 7)), 12'($urandom)};
      lk_asid = 8'($urandom_range(0, 2));
      lk_acc = 2'($urandom_range(0, 3));
      if (r < 15) begin
        fill_valid = 1'b1; fill_vpn = 20'($urandom_range(0, 7)); fill_asid = 8'($urandom_range(0, 2));
        fill_pfn = 20'($urandom); fill_perm = 3'($urandom_range(0, 7));
      end
      if (r >= 97) begin
        flush = 1'b1; flush_all = (r == 99); flush_asid = 8'($urandom_range(0, 2));
      end
      cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule